// File: doc/BRIEF.md
# PCI Interrupt to ISA IRQ Router

This block connects a small set of level-sensitive PCI interrupt lines to a bank of ISA interrupt request lines. Each PCI line has its own 8-bit steering register, written and read over a byte-wide configuration port. When the value in a steering register is below the ISA line count, it names the ISA IRQ that the PCI line drives. A value at or above that count leaves the PCI line unconnected.

When several PCI lines are steered to the same ISA IRQ, their levels are combined by a wired-OR. Any ISA IRQ that no connected PCI line selects is held low. The outputs follow the steering registers and the input levels combinationally, so a new steering value changes the outputs in the same cycle the register updates.

The steering registers sit at consecutive configuration offsets starting at a parameterised base, which defaults to 0x60. At reset every register holds 0x80, so no PCI line is routed.

Top module: `irq_steer_top`

## Requirements
- R1: After reset every steering register reads 0x80 and all sixteen ISA IRQ outputs are low.
- R2: Steering register k (k = 0..3) is located at configuration offset 0x60+k. A write with cfg_we high at that offset stores all eight bits of cfg_wdata on the rising clock edge.
- R3: Reading offset 0x60+k returns on cfg_rdata, combinationally, the last value written to register k. Any other offset reads 0x00.
- R4: A write to an offset outside 0x60..0x63 changes no steering register.
- R5: When the value in register k is below 16, PCI line k (pci_lvl[k]) drives the ISA IRQ whose number equals the low four bits of that value.
- R6: When the value in register k is 16 or more, PCI line k affects no ISA IRQ output.
- R7: Each isa_irq[n] is the OR of every pci_lvl[k] whose register holds the value n. It is low when no such k exists.
- R8: The outputs respond combinationally to pci_lvl and to the registered steering values, with no extra pipeline stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr |
| pci_lvl | input | 4 | PCI interrupt levels, lines 0..3 |
| isa_irq | output | 16 | ISA IRQ levels |

## Verification
The bench targets the following corner cases, each paired with the fault it would expose:
- **Boundary steering values 15, 16, 0x80 and 0xFF.** A design that tests only the low nibble would route 16 to IRQ0.
- **All four lines steered to one IRQ.** A design that lets the last line win, instead of OR-ing, would lose levels.
- **Lines aimed at IRQs 0 and 15.** These catch off-by-one decode errors.
- **Writes just outside the window (0x5F and 0x64).** An address compare that is too loose would corrupt a register, which the bench detects by read-back.

Random steering values and levels are then compared against a reference computed in the bench.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
   localparam int unsigned ADDR_W  = 8;
   localparam int unsigned DATA_W  = 8;
   localparam logic [DATA_W-1:0] STEER_RST = 8'h80;
   typedef logic [DATA_W-1:0] steer_t;
endpackage

// File: rtl/irq_steer_regs.sv
module irq_steer_regs
   import irq_steer_pkg::*;
#(
   parameter int unsigned N_LINES = 4,
   parameter int unsigned BASE    = 8'h60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   output steer_t            steer [N_LINES]
);
   localparam int unsigned LAST = BASE + N_LINES - 1;

   initial begin
      assert (N_LINES >= 1) else $error("N_LINES must be at least 1");
      assert (LAST < (1 << ADDR_W)) else $error("register window exceeds address space");
   end

   logic [N_LINES-1:0] hit;

   for (genvar k = 0; k < N_LINES; k++) begin : g_reg
      assign hit[k] = (cfg_addr == ADDR_W'(BASE + k));
      always_ff @(posedge clk) begin
         if (!rst_n)                steer[k] <= STEER_RST;
         else if (cfg_we && hit[k]) steer[k] <= cfg_wdata;
      end

      // R4: an unselected register keeps its value
      a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !(cfg_we && hit[k]) |=> $stable(steer[k]));
      // R2: a selected write stores the data
      a_r2_store: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_we && hit[k]) |=> steer[k] == $past(cfg_wdata));
   end

   always_comb begin
      cfg_rdata = '0;
      for (int k = 0; k < N_LINES; k++)
         if (hit[k]) cfg_rdata = steer[k];
   end

   a_r3_onehot_hit: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit));
endmodule

// File: rtl/irq_steer_decode.sv
module irq_steer_decode
   import irq_steer_pkg::*;
#(
   parameter int unsigned N_IRQ = 16
) (
   input  steer_t           steer,
   input  logic             lvl,
   output logic [N_IRQ-1:0] req
);
   localparam int unsigned SEL_W = $clog2(N_IRQ);

   initial assert (N_IRQ >= 2 && N_IRQ <= 256) else $error("N_IRQ out of range");

   logic valid;
   assign valid = (32'(steer) < N_IRQ);

   always_comb begin
      req = '0;
      if (valid && lvl) req[steer[SEL_W-1:0]] = 1'b1;
   end

   // R6: an out-of-range steering value drives nothing
   always_comb a_r6_off: assert (valid || req == '0);
   // R5: at most one IRQ per PCI line
   always_comb a_r5_single: assert ($countones(req) <= 1);
endmodule

// File: rtl/irq_steer_top.sv
module irq_steer_top
   import irq_steer_pkg::*;
#(
   parameter int unsigned N_LINES = 4,
   parameter int unsigned N_IRQ   = 16,
   parameter int unsigned BASE    = 8'h60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic [N_LINES-1:0] pci_lvl,
   output logic [N_IRQ-1:0]  isa_irq
);
   steer_t           steer [N_LINES];
   logic [N_IRQ-1:0] req   [N_LINES];

   irq_steer_regs #(.N_LINES(N_LINES), .BASE(BASE)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .steer(steer));

   for (genvar k = 0; k < N_LINES; k++) begin : g_dec
      irq_steer_decode #(.N_IRQ(N_IRQ)) u_dec (
         .steer(steer[k]), .lvl(pci_lvl[k]), .req(req[k]));
   end

   always_comb begin
      isa_irq = '0;
      for (int k = 0; k < N_LINES; k++) isa_irq |= req[k];
   end

   // R7: an active IRQ needs at least one active input
   a_r7_source: assert property (@(posedge clk) disable iff (!rst_n)
      (isa_irq != '0) |-> (pci_lvl != '0));
   // R1: first cycle after reset shows no IRQ
   a_r1_quiet: assert property (@(posedge clk)
      !rst_n |=> isa_irq == '0);
endmodule

// File: tb/irq_steer_top_tb.sv
module irq_steer_top_tb;
   logic clk = 0, rst_n = 0, cfg_we = 0;
   logic [7:0] cfg_addr = 0, cfg_wdata = 0, cfg_rdata;
   logic [3:0] pci_lvl = 0;
   logic [15:0] isa_irq;
   int total = 0, bad = 0;
   logic [7:0] model [4];
   bit done = 0;

   always #2.5 clk = ~clk;

   irq_steer_top u_dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pci_lvl(pci_lvl), .isa_irq(isa_irq));

   function automatic logic [15:0] ref_irq(logic [3:0] lv);
      logic [15:0] r = '0;
      for (int k = 0; k < 4; k++)
         if (model[k] < 16 && lv[k]) r[model[k][3:0]] = 1'b1;
      return r;
   endfunction

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk); cfg_we = 0;
      if (a >= 8'h60 && a <= 8'h63) model[a-8'h60] = d;
   endtask

   task automatic rd_all(string req);
      for (int k = 0; k < 4; k++) begin
         cfg_addr = 8'(8'h60 + k); #1;
         chk(req, {8'h0, cfg_rdata}, {8'h0, model[k]});
      end
   endtask

   task automatic lvl_sweep(string req);
      for (int v = 0; v < 16; v++) begin
         pci_lvl = 4'(v); #1;
         chk(req, isa_irq, ref_irq(4'(v)));
      end
   endtask

   initial begin
      #400000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1234));
      for (int k = 0; k < 4; k++) model[k] = 8'h80;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      rd_all("R1");
      pci_lvl = 4'hF; #1; chk("R1", isa_irq, 16'h0);
      // R2 R3 store and read back
      wr(8'h60, 8'h00); wr(8'h61, 8'h0F); wr(8'h62, 8'h10); wr(8'h63, 8'hFF);
      rd_all("R2");
      cfg_addr = 8'h64; #1; chk("R3", {8'h0, cfg_rdata}, 16'h0);
      // R5 R6 boundaries
      lvl_sweep("R5");
      pci_lvl = 4'b1100; #1; chk("R6", isa_irq, 16'h0);
      // R4 writes outside window
      wr(8'h5F, 8'h03); wr(8'h64, 8'h04);
      rd_all("R4");
      // R7 sharing: all on IRQ 9
      for (int k = 0; k < 4; k++) wr(8'(8'h60 + k), 8'h09);
      lvl_sweep("R7");
      // R8: routing change visible right after the write edge
      pci_lvl = 4'b0001;
      @(negedge clk); cfg_we = 1; cfg_addr = 8'h60; cfg_wdata = 8'h05;
      @(posedge clk); #1; model[0] = 8'h05;
      chk("R8", isa_irq, 16'h0020);
      @(negedge clk); cfg_we = 0;
      // random
      for (int i = 0; i < 300; i++) begin
         logic [7:0] d = 8'($urandom_range(0, 31));
         if (($urandom & 7) == 0) d = 8'($urandom);
         wr(8'(8'h5E + $urandom_range(0, 7)), d);
         pci_lvl = 4'($urandom); #1;
         chk("R7", isa_irq, ref_irq(pci_lvl));
         if (i % 50 == 0) rd_all("R3");
      end
      // reset again
      @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
      for (int k = 0; k < 4; k++) model[k] = 8'h80;
      rd_all("R1");
      pci_lvl = 4'hF; #1; chk("R1", isa_irq, 16'h0);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule